// File: doc/BRIEF.md
# Fault-Detection-Driven Test Vector Qualifier

This block steps a 36-bit pseudo-random pattern source and presents each pattern on one output bus. A fault-free copy of the circuit under test and several fault-injected copies sit outside the block and all receive that pattern. Their responses come back as one reference bus and one wide bus holding every faulty copy's response side by side.

The block registers the responses together with the pattern that produced them. One cycle later it forms a detect flag for each faulty copy and counts how many copies were caught. A pattern whose count is at least the set-point is kept: it is written into an internal result memory next to its per-copy flags, and the kept counter advances. Any other pattern is dropped.

A start pulse begins a run. The run ends by itself once a fixed number of patterns has been kept. After that the stored rows can be read back through a registered read port. The number of patterns evaluated is also reported, so the ratio of kept patterns to evaluated patterns can be checked.

Top module: `tv_qualifier`

## Requirements
- R1: After reset, `done` and `running` are 0, both counters are 0, and `pat_o` holds the seed 36'hF59611D09.
- R2: While `running` is 1, `pat_o` advances once per clock. The new value is the old value shifted left by one, with the XOR of old bits 35 and 34 placed in bit 0. The first pattern of every run is the seed.
- R3: The detect flag of copy i is 1 exactly when any bit of copy i's response slice `cut_resp[i*OUT_W +: OUT_W]` differs from `ref_resp` for that pattern.
- R4: Every evaluated pattern increments `applied_cnt`. A pattern is kept, and `kept_cnt` incremented, when the number of set detect flags is greater than or equal to the set-point.
- R5: Kept patterns fill memory rows 0, 1, 2 … in the order they were kept. Row bits [35:0] hold the pattern, and bit 36+i holds copy i's detect flag. `rd_data` shows the row addressed by `rd_addr` one clock after the address is applied.
- R6: When the 100th pattern is kept, `done` rises and `running` falls on the same edge. Afterwards `pat_o`, `kept_cnt` and `applied_cnt` stay frozen, and the count of evaluated patterns includes the 100th kept pattern.
- R7: The set-point is captured on the start pulse. Changing `setpoint` during a run has no effect on which patterns are kept.
- R8: A start pulse is ignored while a run is active. A start pulse after `done` begins a new run: the source is reloaded with the seed, the counters are cleared, and `done` is cleared.
- R9: With a set-point of 0, every evaluated pattern is kept, so a run ends with `applied_cnt` equal to `kept_cnt` equal to 100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a run when no run is active |
| setpoint | input | 3 | Minimum number of detecting copies for a pattern to be kept |
| pat_o | output | 36 | Pattern presented to the reference and faulty copies |
| ref_resp | input | 2 | Response of the fault-free copy |
| cut_resp | input | 8 | Responses of the faulty copies, copy i in slice i*2 +: 2 |
| running | output | 1 | A run is in progress |
| done | output | 1 | The kept limit was reached |
| kept_cnt | output | 7 | Number of patterns kept in this run |
| applied_cnt | output | 20 | Number of patterns evaluated in this run |
| rd_addr | input | 7 | Result memory read row |
| rd_data | output | 40 | Registered row contents: flags above pattern |

## Verification
The hardest situation to reach from the ports is the last kept pattern. On that edge the run must stop, and the pattern already captured behind the last kept one must be dropped without being counted or stored. The bench reaches this edge with several mock fault maps and set-points, including a strict one that rejects most patterns. For each run it predicts the exact evaluated count, compares it with `applied_cnt`, and then reads back all 100 rows. During one run it also changes the set-point input and pulses start, and then shows that neither changed the stored rows.

// File: rtl/tvq_pkg.sv
package tvq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } tvq_state_e;

  localparam logic [35:0] TVQ_SEED = 36'hF59611D09;
endpackage

// File: rtl/tvq_lfsr.sv
module tvq_lfsr #(
  parameter int          W    = 36,
  parameter logic [W-1:0] SEED = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt;

  always_comb nxt = {q[W-2:0], q[W-1] ^ q[W-2]};

  always_ff @(posedge clk) begin
    if (rst || load) q <= SEED;
    else if (step)   q <= nxt;
  end
endmodule

// File: rtl/tvq_detect.sv
module tvq_detect #(
  parameter int N_COPIES = 4,
  parameter int OUT_W    = 2,
  parameter int SP_W     = 3
) (
  input  logic [OUT_W-1:0]          ref_r,
  input  logic [N_COPIES*OUT_W-1:0] cut_r,
  output logic [N_COPIES-1:0]       flags,
  output logic [SP_W-1:0]           hits
);
  genvar gi;
  generate
    for (gi = 0; gi < N_COPIES; gi++) begin : g_copy
      assign flags[gi] = |(ref_r ^ cut_r[gi*OUT_W +: OUT_W]);
    end
  endgenerate

  always_comb begin
    hits = '0;
    for (int i = 0; i < N_COPIES; i++) hits = hits + SP_W'(flags[i]);
  end
endmodule

// File: rtl/tvq_store.sv
module tvq_store #(
  parameter int ROWS   = 100,
  parameter int ROW_W  = 40,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [ROW_W-1:0]  wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [ROW_W-1:0]  rdata
);
  logic [ROW_W-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tv_qualifier.sv
module tv_qualifier #(
  parameter int PAT_W      = 36,
  parameter int N_COPIES   = 4,
  parameter int OUT_W      = 2,
  parameter int KEEP_MAX   = 100,
  parameter int APPLIED_W  = 20,
  localparam int SP_W      = $clog2(N_COPIES + 1),
  localparam int CNT_W     = $clog2(KEEP_MAX + 1),
  localparam int ADDR_W    = $clog2(KEEP_MAX),
  localparam int ROW_W     = PAT_W + N_COPIES
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [SP_W-1:0]           setpoint,
  output logic [PAT_W-1:0]          pat_o,
  input  logic [OUT_W-1:0]          ref_resp,
  input  logic [N_COPIES*OUT_W-1:0] cut_resp,
  output logic                      running,
  output logic                      done,
  output logic [CNT_W-1:0]          kept_cnt,
  output logic [APPLIED_W-1:0]      applied_cnt,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [ROW_W-1:0]          rd_data
);
  import tvq_pkg::*;

  tvq_state_e               state;
  logic [SP_W-1:0]          sp_q;
  logic                     s1_valid;
  logic [PAT_W-1:0]         s1_pat;
  logic [OUT_W-1:0]         s1_ref;
  logic [N_COPIES*OUT_W-1:0] s1_cut;
  logic [N_COPIES-1:0]      flags;
  logic [SP_W-1:0]          hits;
  logic                     go, qualify, last_keep, lfsr_step;

  assign go        = start && (state != ST_RUN);
  assign qualify   = s1_valid && (hits >= sp_q);
  assign last_keep = qualify && (kept_cnt == CNT_W'(KEEP_MAX - 1));
  assign lfsr_step = (state == ST_RUN) && !last_keep;

  tvq_lfsr #(.W(PAT_W), .SEED(PAT_W'(TVQ_SEED))) u_lfsr (
    .clk (clk),
    .rst (rst),
    .load(go),
    .step(lfsr_step),
    .q   (pat_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_pat   <= '0;
      s1_ref   <= '0;
      s1_cut   <= '0;
    end else begin
      s1_valid <= lfsr_step;
      s1_pat   <= pat_o;
      s1_ref   <= ref_resp;
      s1_cut   <= cut_resp;
    end
  end

  tvq_detect #(.N_COPIES(N_COPIES), .OUT_W(OUT_W), .SP_W(SP_W)) u_detect (
    .ref_r(s1_ref),
    .cut_r(s1_cut),
    .flags(flags),
    .hits (hits)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      sp_q        <= '0;
      kept_cnt    <= '0;
      applied_cnt <= '0;
    end else if (go) begin
      state       <= ST_RUN;
      sp_q        <= setpoint;
      kept_cnt    <= '0;
      applied_cnt <= '0;
    end else if (state == ST_RUN) begin
      if (s1_valid) applied_cnt <= applied_cnt + 1'b1;
      if (qualify)  kept_cnt    <= kept_cnt + 1'b1;
      if (last_keep) state      <= ST_DONE;
    end
  end

  assign running = (state == ST_RUN);
  assign done    = (state == ST_DONE);

  tvq_store #(.ROWS(KEEP_MAX), .ROW_W(ROW_W), .ADDR_W(ADDR_W)) u_store (
    .clk  (clk),
    .we   (qualify),
    .waddr(kept_cnt[ADDR_W-1:0]),
    .wdata({flags, s1_pat}),
    .raddr(rd_addr),
    .rdata(rd_data)
  );
endmodule

// File: rtl/tvq_checker.sv
module tvq_checker #(
  parameter int PAT_W     = 36,
  parameter int CNT_W     = 7,
  parameter int APPLIED_W = 20,
  parameter int KEEP_MAX  = 100
) (
  input logic                 clk,
  input logic                 rst,
  input logic [PAT_W-1:0]     pat_o,
  input logic                 running,
  input logic                 done,
  input logic [CNT_W-1:0]     kept_cnt,
  input logic [APPLIED_W-1:0] applied_cnt
);
  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (rst)
    !(running && done)); // R6

  AST_SOURCE_STEP: assert property (@(posedge clk) disable iff (rst)
    ($past(running) && running) |->
      pat_o == {$past(pat_o[PAT_W-2:0]), $past(pat_o[PAT_W-1]) ^ $past(pat_o[PAT_W-2])}); // R2

  AST_DONE_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> kept_cnt == CNT_W'(KEEP_MAX)); // R6

  AST_DONE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    ($past(done) && done) |-> ($stable(pat_o) && $stable(kept_cnt) && $stable(applied_cnt))); // R6

  AST_KEPT_STEP: assert property (@(posedge clk) disable iff (rst)
    $past(running) |-> (kept_cnt == $past(kept_cnt) || kept_cnt == $past(kept_cnt) + 1'b1)); // R4

  AST_KEPT_IMPLIES_APPLIED: assert property (@(posedge clk) disable iff (rst)
    ($past(running) && kept_cnt != $past(kept_cnt)) |-> applied_cnt != $past(applied_cnt)); // R4

  AST_KEPT_BOUND: assert property (@(posedge clk) disable iff (rst)
    kept_cnt <= CNT_W'(KEEP_MAX)); // R6
endmodule

bind tv_qualifier tvq_checker #(
  .PAT_W(PAT_W), .CNT_W(CNT_W), .APPLIED_W(APPLIED_W), .KEEP_MAX(KEEP_MAX)
) u_chk (
  .clk(clk), .rst(rst), .pat_o(pat_o), .running(running), .done(done),
  .kept_cnt(kept_cnt), .applied_cnt(applied_cnt)
);

// File: tb/tb_tv_qualifier.sv
module tb_tv_qualifier;
  localparam logic [35:0] SEED = 36'hF59611D09;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  setpoint = '0;
  logic [35:0] pat_o;
  logic [1:0]  ref_resp;
  logic [7:0]  cut_resp;
  logic        running, done;
  logic [6:0]  kept_cnt;
  logic [19:0] applied_cnt;
  logic [6:0]  rd_addr = '0;
  logic [39:0] rd_data;
  logic [3:0]  fault_en = '0;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [39:0] exp_row [100];
  int exp_applied;

  always #2.5 clk = ~clk;

  tv_qualifier dut (
    .clk(clk), .rst(rst), .start(start), .setpoint(setpoint), .pat_o(pat_o),
    .ref_resp(ref_resp), .cut_resp(cut_resp), .running(running), .done(done),
    .kept_cnt(kept_cnt), .applied_cnt(applied_cnt), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // Mock circuits: copy i flips response bit (i%2) when enabled and pattern bit i+2 is set.
  assign ref_resp = pat_o[1:0];
  always_comb begin
    for (int i = 0; i < 4; i++)
      cut_resp[i*2 +: 2] = pat_o[1:0] ^
        ((fault_en[i] && pat_o[i+2]) ? (2'b01 << (i % 2)) : 2'b00);
  end

  function automatic logic [35:0] step(logic [35:0] p);
    return {p[34:0], p[35] ^ p[34]};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model(logic [2:0] sp, logic [3:0] en);
    logic [35:0] p = SEED;
    int k = 0;
    exp_applied = 0;
    while (k < 100) begin
      logic [3:0] f = en & p[5:2];
      exp_applied++;
      if ($countones(f) >= sp) begin
        exp_row[k] = {f, p};
        k++;
      end
      p = step(p);
    end
  endtask

  task automatic pulse_start(logic [2:0] sp);
    @(negedge clk);
    setpoint = sp;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic check_run(string req);
    chk({req, " done"}, 64'(done), 64'd1);
    chk({req, " kept"}, 64'(kept_cnt), 64'd100);
    chk({req, " applied"}, 64'(applied_cnt), 64'(exp_applied));
    for (int r = 0; r < 100; r++) begin
      rd_addr = 7'(r);
      @(negedge clk);
      chk({req, " R5 row"}, 64'(rd_data), 64'(exp_row[r]));
    end
  endtask

  task automatic t_reset();
    chk("R1 done", 64'(done), 0);
    chk("R1 running", 64'(running), 0);
    chk("R1 kept", 64'(kept_cnt), 0);
    chk("R1 applied", 64'(applied_cnt), 0);
    chk("R1 seed", 64'(pat_o), 64'(SEED));
  endtask

  task automatic t_all_kept();
    logic [35:0] p = SEED;
    fault_en = 4'b0000;
    model(3'd0, 4'b0000);
    pulse_start(3'd0);
    chk("R2 running", 64'(running), 1);
    for (int c = 0; c < 8; c++) begin
      chk("R2 step", 64'(pat_o), 64'(p));
      p = step(p);
      @(negedge clk);
    end
    wait_done();
    chk("R9 applied==kept", 64'(applied_cnt), 64'(kept_cnt));
    check_run("R9");
  endtask

  task automatic t_threshold();
    fault_en = 4'b1111;
    model(3'd2, 4'b1111);
    pulse_start(3'd2);
    repeat (5) @(negedge clk);
    setpoint = 3'd0;           // R7: must be ignored
    start = 1'b1;              // R8: ignored while running
    @(negedge clk);
    start = 1'b0;
    chk("R8 still running", 64'(running), 1);
    wait_done();
    check_run("R3 R4 R7");
  endtask

  task automatic t_frozen();
    logic [35:0] p = pat_o;
    logic [6:0]  k = kept_cnt;
    logic [19:0] a = applied_cnt;
    repeat (6) @(negedge clk);
    chk("R6 running low", 64'(running), 0);
    chk("R6 pattern held", 64'(pat_o), 64'(p));
    chk("R6 kept held", 64'(kept_cnt), 64'(k));
    chk("R6 applied held", 64'(applied_cnt), 64'(a));
  endtask

  task automatic t_restart();
    fault_en = 4'b1011;
    model(3'd3, 4'b1011);
    pulse_start(3'd3);
    chk("R8 done cleared", 64'(done), 0);
    chk("R8 reseed", 64'(pat_o), 64'(SEED));
    chk("R8 kept cleared", 64'(kept_cnt), 0);
    wait_done();
    check_run("R8 R3");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_all_kept();
    t_threshold();
    t_frozen();
    t_restart();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule